// File: doc/BRIEF.md
# Self-Recovering Decade Counter

This block is a single-digit synchronous decade counter. While counting is enabled it advances through the codes 0000 to 1001 on each rising clock edge and then returns to 0000. The next-state equations are fixed two-level sum-of-products forms. Because of this, each of the six codes that are not decimal digits also has a defined successor. The digit leaves those codes without outside help.

The counter can be set to a known digit through a synchronous load. Reset is synchronous and active-high. A carry output is raised while the digit is nine and counting is enabled. Several such digits can be chained: the carry of one digit drives the enable of the next.

Top module: `bcd_selfheal_counter`

## Requirements
- R1: A clock edge with `rst` high sets `q` to 0000, whatever `ld` and `en` are doing. Reset wins over load.
- R2: With `rst` and `ld` low and `en` high, a `q` holding a value from 0 to 8 becomes that value plus one at the next edge.
- R3: With `rst` and `ld` low and `en` high, `q` = 1001 becomes 0000 at the next edge.
- R4: With `rst`, `ld` and `en` all low, `q` keeps its value across the edge, and this includes the codes 1010 to 1111.
- R5: With `ld` high and `rst` low, `q` takes `ld_val` at the next edge, whatever `en` is. All sixteen 4-bit codes are accepted.
- R6: `tc` is 1 exactly when `q` is 1001 and `en` is 1. It is combinational from `q` and `en`.
- R7: With counting enabled, each unused code steps to a fixed successor: 1010 to 1011, 1011 to 0100, 1100 to 1101, 1101 to 0100, 1110 to 1111, 1111 to 1000.
- R8: Starting from any unused code, at most two enabled clock edges bring `q` back into the range 0000 to 1001. The odd codes need one edge and the even codes need two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable |
| ld | input | 1 | Synchronous load strobe |
| ld_val | input | 4 | Code written into the digit when `ld` is high |
| q | output | 4 | Registered digit; bit 3 has weight 8, bit 0 has weight 1 |
| tc | output | 1 | Carry out: high when the digit is nine and `en` is high |

## Verification
The four register-driven results (reset, load, count step and hold) appear on `q` one clock edge after the cycle in which they are driven. `tc` follows `en` and `q` in the same cycle. The bench therefore changes the inputs on the falling edge and checks `q` shortly after the next rising edge. It checks `tc` shortly after changing `en`, before that rising edge arrives. Every one of the sixteen codes is loaded and then stepped once, and the result is compared with the value computed from the rules. Each unused code is then loaded again and followed for two edges to confirm recovery.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int DIGIT_W = 4;
  localparam int LAST_DIGIT = 9;
  typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/bcd_next_logic.sv
module bcd_next_logic
  import bcd_pkg::*;
(
  input  digit_t cur,
  output digit_t nxt
);
  // Minimised equations; unused codes fall back into the sequence.
  always_comb begin
    nxt[3] = (cur[3] & ~cur[0]) | (cur[0] & cur[1] & cur[2]);
    nxt[2] = cur[2] ^ (cur[0] & cur[1]);
    nxt[1] = (cur[1] & ~cur[0]) | (~cur[3] & ~cur[1] & cur[0]);
    nxt[0] = ~cur[0];
  end
endmodule

// File: rtl/bcd_digit_reg.sv
module bcd_digit_reg
  import bcd_pkg::*;
#(
  parameter digit_t RESET_CODE = '0
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   en,
  input  logic   ld,
  input  digit_t ld_val,
  input  digit_t step_val,
  output digit_t q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RESET_CODE;
    else if (ld) q <= ld_val;
    else if (en) q <= step_val;
  end

  a_r1_reset_wins: assert property (@(posedge clk) rst |=> q == RESET_CODE);
  a_r5_load: assert property (@(posedge clk) disable iff (rst)
    ld |=> q == $past(ld_val));
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!ld && !en) |=> $stable(q));
endmodule

// File: rtl/bcd_tc_detect.sv
module bcd_tc_detect
  import bcd_pkg::*;
(
  input  digit_t q,
  input  logic   en,
  output logic   tc
);
  localparam digit_t TC_CODE = digit_t'(LAST_DIGIT);
  assign tc = en && (q == TC_CODE);
endmodule

// File: rtl/bcd_selfheal_counter.sv
module bcd_selfheal_counter
  import bcd_pkg::*;
#(
  parameter digit_t RESET_CODE = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 ld,
  input  logic [DIGIT_W-1:0]   ld_val,
  output logic [DIGIT_W-1:0]   q,
  output logic                 tc
);
  localparam digit_t MAX_CODE = digit_t'(LAST_DIGIT);

  digit_t step_val;
  digit_t q_int;

  bcd_next_logic u_next (.cur(q_int), .nxt(step_val));

  bcd_digit_reg #(.RESET_CODE(RESET_CODE)) u_reg (
    .clk(clk), .rst(rst), .en(en), .ld(ld),
    .ld_val(ld_val), .step_val(step_val), .q(q_int)
  );

  bcd_tc_detect u_tc (.q(q_int), .en(en), .tc(tc));

  assign q = q_int;

  a_r2_increment: assert property (@(posedge clk) disable iff (rst)
    (en && !ld && q_int < MAX_CODE) |=> q_int == $past(q_int) + 4'd1);
  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    (en && !ld && q_int == MAX_CODE) |=> q_int == '0);
  a_r6_carry_wraps: assert property (@(posedge clk) disable iff (rst)
    (tc && !ld) |=> q_int == '0);
  a_r8_odd_recover: assert property (@(posedge clk) disable iff (rst)
    (en && !ld && q_int > MAX_CODE && q_int[0]) |=> q_int <= MAX_CODE);
  a_r8_even_to_odd: assert property (@(posedge clk) disable iff (rst)
    (en && !ld && q_int > MAX_CODE && !q_int[0]) |=> q_int[0]);
endmodule

// File: tb/bcd_selfheal_counter_tb.sv
module bcd_selfheal_counter_tb;
  logic clk = 0;
  logic rst, en, ld;
  logic [3:0] ld_val;
  logic [3:0] q;
  logic tc;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bcd_selfheal_counter u_dut (
    .clk(clk), .rst(rst), .en(en), .ld(ld), .ld_val(ld_val), .q(q), .tc(tc)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One edge with the given inputs; q sampled 1 ns after the rising edge.
  task automatic cycle(input logic r, input logic e, input logic l, input logic [3:0] v);
    @(negedge clk);
    rst = r; en = e; ld = l; ld_val = v;
    @(posedge clk);
    #1;
  endtask

  function automatic int expect_step(input int v);
    case (v)
      10: return 11;
      11: return 4;
      12: return 13;
      13: return 4;
      14: return 15;
      15: return 8;
      default: return (v + 1) % 10;
    endcase
  endfunction

  initial begin
    rst = 1; en = 0; ld = 0; ld_val = 0;
    cycle(1, 0, 0, 0);
    check("R1 reset q", q, 0);
    check("R1 reset tc", tc, 0);

    // R2/R3: full count sweep from zero
    for (int i = 1; i <= 20; i++) begin
      cycle(0, 1, 0, 0);
      check("R2/R3 count", q, i % 10);
    end

    // R5, R7, R2, R3: load every code (with en both ways), then step once
    for (int v = 0; v < 16; v++) begin
      cycle(0, v[0], 1, 4'(v));
      check("R5 load", q, v);
      #3; en = 1; #1;
      check("R6 tc", tc, (v == 9) ? 1 : 0);
      @(negedge clk); en = 0; #1;
      check("R6 tc low when disabled", tc, 0);
      cycle(0, 1, 0, 0);
      check(v > 9 ? "R7 unused step" : "R2/R3 step", q, expect_step(v));
    end

    // R8: recovery within two edges from each unused code
    for (int v = 10; v < 16; v++) begin
      cycle(0, 0, 1, 4'(v));
      cycle(0, 1, 0, 0);
      if (v % 2 == 1) check("R8 one-edge recovery", (q <= 9) ? 1 : 0, 1);
      cycle(0, 1, 0, 0);
      check("R8 two-edge recovery", (q <= 9) ? 1 : 0, 1);
      check("R8 exact path", q, expect_step(expect_step(v)));
    end

    // R4: hold, including unused codes
    for (int v = 0; v < 16; v += 5) begin
      cycle(0, 0, 1, 4'(v));
      for (int k = 0; k < 3; k++) begin
        cycle(0, 0, 0, 4'(15 - v));
        check("R4 hold", q, v);
      end
    end

    // R1: reset beats load
    cycle(0, 0, 1, 4'd7);
    cycle(1, 1, 1, 4'd5);
    check("R1 reset over load", q, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule